// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

A 32-bit countdown timer that raises an interrupt request toward an interrupt controller when it expires. The count advances on ticks from a power-of-two prescaler that runs off the processor clock. Software programs three registers through a simple single-cycle write port: a timer entry (vector number, mask bit, periodic bit), a start value, and a divide setting. The live count is always visible on an output.

In one-shot mode the count runs down from the start value and stays at zero, and the timer fires once. In periodic mode the count reloads after reaching zero and fires at the end of every period. A fire produces a one-cycle request pulse with the programmed 8-bit vector alongside.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the timer entry is masked with vector 0 and one-shot mode, the start value and divide setting are 0 (so the prescaler divides by 2), the live count is 0 and no pulse is driven.
- R2: A divide-setting write (select 2) keeps data bits 3, 1 and 0 as v = {bit3, bit1, bit0} and ignores all other bits. A tick then occurs every 2^((v+1) mod 8) clocks, so v = 7 gives one tick per clock.
- R3: A timer-entry write (select 0) takes the vector from data bits 7:0, the mask from bit 16 and periodic mode from bit 17. Every pulse carries the vector that was programmed when it fired.
- R4: In one-shot mode the live count equals start value minus elapsed ticks and holds at 0. One pulse fires (start value + 1) ticks after the load, and none after that. A start value of 0 never fires.
- R5: In periodic mode the count steps from the start value down to 0 and then reloads. A pulse fires at every reload, so the period is (start value + 1) ticks.
- R6: In periodic mode a start value of 0 produces no pulses.
- R7: A start-value write (select 1) loads the count and restarts the prescaler at once. A countdown already in progress is abandoned.
- R8: While the mask bit is set no pulse is driven, but the count keeps running. Clearing the mask before expiry restores the pulse at its scheduled tick.
- R9: A write with select 3 (the live-count position) changes nothing.
- R10: Each pulse lasts exactly one clock.
- R11: A new divide setting takes effect only at the next tick of the divider that is currently active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 0 entry, 1 start value, 2 divide, 3 live count (ignored) |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Live count value |
| irq_pulse | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The assertions check on every cycle that a pulse never lasts past one clock, that the mask bit and a periodic zero start value both keep the request quiet, and that the vector on a pulse matches the programmed entry. They also check that a running count only holds or steps down by one, and that a finished one-shot count stays at zero. The exact fire cycle for each divide code, the periodic reload sequence, the restart on a new start value, the late adoption of a divide change and the ignored write to the live count depend on a programmed history. Only the bench's directed scenarios can show these, by counting clocks from each load.

// File: rtl/irq_countdown_timer.sv
`timescale 1ns/1ps
module irq_countdown_timer #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cur_count,
  output logic              irq_pulse,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam logic [1:0] SEL_ENTRY = 2'd0;
  localparam logic [1:0] SEL_START = 2'd1;
  localparam logic [1:0] SEL_DIV   = 2'd2;
  localparam int SHIFT_W = 3;
  localparam int PRE_W   = (1 << SHIFT_W) - 1;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;

  logic [VEC_W-1:0]   vec_q;
  logic               mask_q, periodic_q;
  logic [DATA_W-1:0]  init_q, cnt_q;
  logic [SHIFT_W-1:0] div_code_q, shift_q;
  logic [PRE_W-1:0]   pre_q;
  logic               armed_q;

  wire wr_entry = wr_en && (wr_sel == SEL_ENTRY);
  wire wr_start = wr_en && (wr_sel == SEL_START);
  wire wr_div   = wr_en && (wr_sel == SEL_DIV);

  wire [PRE_W-1:0] pre_mask = ~({PRE_W{1'b1}} << shift_q);
  wire tick      = (pre_q == pre_mask);
  wire at_zero   = (cnt_q == '0);
  wire expire    = tick && at_zero && !wr_start &&
                   (periodic_q ? (init_q != '0) : armed_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q      <= '0;
      mask_q     <= 1'b1;
      periodic_q <= 1'b0;
      div_code_q <= '0;
      init_q     <= '0;
    end else begin
      if (wr_entry) begin
        vec_q      <= wr_data[VEC_W-1:0];
        mask_q     <= wr_data[MASK_BIT];
        periodic_q <= wr_data[PER_BIT];
      end
      if (wr_div)   div_code_q <= {wr_data[3], wr_data[1], wr_data[0]};
      if (wr_start) init_q     <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      shift_q <= SHIFT_W'(1);
    end else begin
      if (wr_start || tick) pre_q <= '0;
      else                  pre_q <= pre_q + 1'b1;
      if (tick) shift_q <= div_code_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (wr_start) begin
      cnt_q   <= wr_data;
      armed_q <= (wr_data != '0);
    end else if (tick) begin
      if (!at_zero)        cnt_q   <= cnt_q - 1'b1;
      else if (periodic_q) cnt_q   <= init_q;
      if (at_zero && !periodic_q) armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse <= expire && !mask_q;
      if (expire) irq_vector <= vec_q;
    end
  end

  assign cur_count = cnt_q;
endmodule

// File: rtl/irq_countdown_timer_chk.sv
`timescale 1ns/1ps
module irq_countdown_timer_chk #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] cur_count,
  input logic              irq_pulse,
  input logic [VEC_W-1:0]  irq_vector,
  input logic [VEC_W-1:0]  vec_q,
  input logic              mask_q,
  input logic              periodic_q,
  input logic [DATA_W-1:0] init_q
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R10
  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |=> !irq_pulse); // R8
  AST_PERIODIC_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic_q && init_q == '0) |=> !irq_pulse); // R6
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic_q && cur_count == '0 && !wr_en) |=> cur_count == '0); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count != '0 && !wr_en) |=>
      (cur_count == $past(cur_count) || cur_count == $past(cur_count) - 1'b1)); // R5
  AST_VEC_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_vector == $past(vec_q)); // R3
endmodule

bind irq_countdown_timer irq_countdown_timer_chk #(.DATA_W(DATA_W), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cur_count(cur_count),
  .irq_pulse(irq_pulse), .irq_vector(irq_vector), .vec_q(vec_q),
  .mask_q(mask_q), .periodic_q(periodic_q), .init_q(init_q)
);

// File: tb/irq_countdown_timer_tb_top.sv
`timescale 1ns/1ps
module irq_countdown_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_count;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int m_first, m_num;
  logic [7:0] m_vec;

  always #4 clk = ~clk;

  irq_countdown_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cur_count(cur_count), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic entry(logic per, logic msk, logic [7:0] v);
    wr(2'd0, {14'd0, per, msk, 8'd0, v});
  endtask

  task automatic set_div(logic [31:0] d);
    wr(2'd2, d);
    repeat (140) @(negedge clk);
  endtask

  task automatic measure(int limit);
    m_first = -1; m_num = 0; m_vec = '0;
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      if (irq_pulse) begin
        if (m_num == 0) begin m_first = n; m_vec = irq_vector; end
        m_num++;
      end
    end
  endtask

  task automatic t_reset();
    chk("R1 count after reset", cur_count, 0);
    chk("R1 no pulse after reset", irq_pulse, 0);
    wr(2'd1, 32'd3);
    repeat (30) @(negedge clk);
    chk("R1 masked at reset", irq_pulse, 0);
    entry(1'b0, 1'b0, 8'h21);
    wr(2'd1, 32'd3);
    measure(30);
    chk("R1 default divide by 2 fire cycle", m_first, 8);
  endtask

  task automatic t_div(logic [31:0] d, int ic, int expc);
    entry(1'b0, 1'b0, 8'h11);
    set_div(d);
    wr(2'd1, ic);
    measure(expc + 40);
    chk($sformatf("R2 div 0x%0h fire cycle", d), m_first, expc);
    chk($sformatf("R2 div 0x%0h pulse count", d), m_num, 1);
  endtask

  task automatic t_oneshot();
    entry(1'b0, 1'b0, 8'h5A);
    set_div(32'hB);
    wr(2'd1, 32'd5);
    repeat (3) @(negedge clk);
    chk("R4 count after 3 ticks", cur_count, 2);
    repeat (2) @(negedge clk);
    chk("R4 count reaches zero", cur_count, 0);
    @(negedge clk);
    chk("R4 pulse one tick after zero", irq_pulse, 1);
    chk("R3 vector carried", irq_vector, 8'h5A);
    @(negedge clk);
    chk("R10 pulse one clock wide", irq_pulse, 0);
    measure(40);
    chk("R4 no second pulse", m_num, 0);
    chk("R4 count holds zero", cur_count, 0);
    wr(2'd1, 32'd0);
    measure(40);
    chk("R4 zero start never fires", m_num, 0);
  endtask

  task automatic t_periodic();
    entry(1'b1, 1'b0, 8'h33);
    set_div(32'hB);
    wr(2'd1, 32'd3);
    @(negedge clk);
    chk("R5 count steps down", cur_count, 2);
    repeat (3) @(negedge clk);
    chk("R5 reload to start value", cur_count, 3);
    chk("R5 fire at reload", irq_pulse, 1);
    chk("R3 periodic vector", irq_vector, 8'h33);
    measure(12);
    chk("R5 later pulses every 4 ticks", m_first, 4);
    chk("R5 pulse count", m_num, 3);
    wr(2'd1, 32'd0);
    measure(40);
    chk("R6 periodic zero silent", m_num, 0);
  endtask

  task automatic t_restart();
    entry(1'b0, 1'b0, 8'h44);
    set_div(32'hB);
    wr(2'd1, 32'd10);
    measure(5);
    wr(2'd1, 32'd20);
    chk("R7 count reloaded", cur_count, 20);
    measure(30);
    chk("R7 fire measured from rewrite", m_first, 21);
    chk("R7 single pulse", m_num, 1);
  endtask

  task automatic t_mask();
    entry(1'b0, 1'b1, 8'h66);
    set_div(32'hB);
    wr(2'd1, 32'd20);
    measure(5);
    chk("R8 count runs while masked", cur_count, 15);
    chk("R8 no pulse while masked", m_num, 0);
    measure(5);
    entry(1'b0, 1'b0, 8'h66);
    measure(15);
    chk("R8 unmask keeps schedule", m_first, 10);
  endtask

  task automatic t_cur_write();
    entry(1'b0, 1'b1, 8'h01);
    set_div(32'hB);
    wr(2'd1, 32'd50);
    wr(2'd3, 32'd7);
    repeat (4) @(negedge clk);
    chk("R9 live-count write ignored", cur_count, 45);
    wr(2'd3, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    chk("R9 second ignored write", cur_count, 40);
  endtask

  task automatic t_div_late();
    entry(1'b0, 1'b1, 8'h02);
    set_div(32'h8);
    wr(2'd1, 32'd100);
    repeat (10) @(negedge clk);
    wr(2'd2, 32'hB);
    repeat (20) @(negedge clk);
    chk("R11 old divider still active", cur_count, 100);
    repeat (9) @(negedge clk);
    chk("R11 new divider after boundary", cur_count, 91);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_div(32'hB, 5, 6);
    t_div(32'hF4, 3, 8);
    t_div(32'h3, 1, 32);
    t_div(32'h8, 2, 96);
    t_div(32'hA, 1, 256);
    t_oneshot();
    t_periodic();
    t_restart();
    t_mask();
    t_cur_write();
    t_div_late();
    finish_run();
  end
endmodule